// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block predicts the direction of conditional branches. It keeps one history shift register for each of a small number of branch slots. The slot's history, with no address bits mixed in, selects an entry in one shared table of 1-bit counters. A counter holding 1 means taken, and a counter holding 0 means not-taken. Each lookup returns the predicted direction together with the history value that was in place before the lookup. That value is the tag, and the front end keeps it with the branch.

The slot history is advanced at lookup time with the guessed direction, so that a second lookup on the same branch, issued before the first one resolves, already sees the guess. The counter table is written only when a branch resolves, at the entry named by the returned tag and with the actual direction. When a resolution reports a misprediction, the slot's history is rebuilt from the tag and the actual direction. This throws away every younger guess made for that slot.

Top module: `lhist_predictor`

## Requirements
- R1: While reset is high and in the cycle after it, `rsp_valid` is 0. After reset every history register and every counter holds 0, so the first lookup on any slot answers not-taken with tag 0.
- R2: A lookup request (`pred_valid`=1) in cycle N gives `rsp_valid`=1 in cycle N+1. `rsp_taken` is the counter selected by the slot's current history. `rsp_tag` is that pre-lookup history, with the most recent outcome in bit 0.
- R3: A lookup shifts its predicted direction into bit 0 of the slot's history and moves the older bits up by one. The next lookup on that slot therefore reports tag = {previous tag[W-2:0], previous prediction}.
- R4: Each slot owns its own history. A lookup on one slot leaves every other slot's history unchanged.
- R5: A resolution (`res_valid`=1) writes `res_taken` into the counter at index `res_tag`. Later lookups whose history equals that index predict the trained value.
- R6: A resolution with `res_pred` equal to `res_taken` leaves the slot's history unchanged.
- R7: A resolution with `res_pred` different from `res_taken` sets the slot's history to {res_tag[W-2:0], res_taken}. Speculative shifts made on that slot after the resolved branch are discarded.
- R8: If a mispredicted resolution and a lookup target the same slot in the same cycle, the repair is applied first. The lookup uses the repaired history and reports it as its tag.
- R9: If a resolution writes the same counter entry that a lookup reads in the same cycle, the lookup sees the newly written value.
- R10: A cycle without a lookup request gives `rsp_valid`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Lookup request |
| pred_slot | input | SLOT_W | Branch slot to look up |
| res_valid | input | 1 | Resolution of an earlier lookup |
| res_slot | input | SLOT_W | Slot of the resolved branch |
| res_tag | input | HIST_W | Tag returned by that branch's lookup |
| res_pred | input | 1 | Direction that was predicted for it |
| res_taken | input | 1 | Direction actually taken |
| rsp_valid | output | 1 | Lookup response valid (registered) |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_tag | output | HIST_W | Pre-lookup slot history |

## Verification
Every lookup answer comes out of one output register, so it is due exactly one clock edge after the request. Training and history repair take effect at that same edge, and are first seen by a lookup issued in the following cycle. The bench applies each stimulus on the falling edge and samples the response on the next falling edge. It checks the response before it drives the next vector, so every check lands in the one cycle where the answer to a given request is visible. For the cases where a resolution and a lookup meet in the same cycle, the expected values already include the same-edge repair and the same-edge counter write.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  localparam int DEF_SLOTS  = 4;
  localparam int DEF_HIST_W = 4;

  // source chosen for one slot's history update
  typedef enum logic [1:0] {
    HSRC_HOLD   = 2'd0,
    HSRC_SPEC   = 2'd1,
    HSRC_REPAIR = 2'd2
  } hist_src_e;
endpackage

// File: rtl/lhp_resolve.sv
module lhp_resolve #(
  parameter int NUM_SLOTS = lhp_pkg::DEF_SLOTS,
  parameter int HIST_W    = lhp_pkg::DEF_HIST_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              res_valid,
  input  logic [SLOT_W-1:0] res_slot,
  input  logic [HIST_W-1:0] res_tag,
  input  logic              res_pred,
  input  logic              res_taken,
  output logic              train_en,
  output logic [HIST_W-1:0] train_idx,
  output logic              train_bit,
  output logic              fix_en,
  output logic [SLOT_W-1:0] fix_slot,
  output logic [HIST_W-1:0] fix_hist
);
  // lazy training: always at resolve, indexed by pre-shift history
  always_comb begin
    train_en  = res_valid;
    train_idx = res_tag;
    train_bit = res_taken;
  end

  // repair only when the guess was wrong
  always_comb begin
    fix_en   = res_valid && (res_pred != res_taken);
    fix_slot = res_slot;
    fix_hist = {res_tag[HIST_W-2:0], res_taken};
  end
endmodule

// File: rtl/lhp_hist_bank.sv
module lhp_hist_bank #(
  parameter int NUM_SLOTS = lhp_pkg::DEF_SLOTS,
  parameter int HIST_W    = lhp_pkg::DEF_HIST_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              look_en,
  input  logic [SLOT_W-1:0] look_slot,
  input  logic              spec_bit,
  input  logic              fix_en,
  input  logic [SLOT_W-1:0] fix_slot,
  input  logic [HIST_W-1:0] fix_hist,
  output logic [HIST_W-1:0] look_hist
);
  import lhp_pkg::*;

  logic [HIST_W-1:0] hist_q [NUM_SLOTS];
  logic [HIST_W-1:0] spec_hist;

  // repair forwarded to a same-slot lookup in the same cycle
  always_comb begin
    if (fix_en && (fix_slot == look_slot))
      look_hist = fix_hist;
    else
      look_hist = hist_q[look_slot];
    spec_hist = {look_hist[HIST_W-2:0], spec_bit};
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hist_src_e src;

    always_comb begin
      if (look_en && (look_slot == SLOT_W'(s)))
        src = HSRC_SPEC;
      else if (fix_en && (fix_slot == SLOT_W'(s)))
        src = HSRC_REPAIR;
      else
        src = HSRC_HOLD;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[s] <= '0;
      end else begin
        case (src)
          HSRC_SPEC:   hist_q[s] <= spec_hist;
          HSRC_REPAIR: hist_q[s] <= fix_hist;
          default:     hist_q[s] <= hist_q[s];
        endcase
      end
    end
  end
endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table #(
  parameter int HIST_W  = lhp_pkg::DEF_HIST_W,
  localparam int DEPTH  = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_bit,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_bit
);
  logic [DEPTH-1:0] ctr_q;

  always_ff @(posedge clk) begin
    if (rst)
      ctr_q <= '0;
    else if (wr_en)
      ctr_q[wr_idx] <= wr_bit;
  end

  // write-first: a same-cycle write to the read entry is forwarded
  always_comb begin
    if (wr_en && (wr_idx == rd_idx))
      rd_bit = wr_bit;
    else
      rd_bit = ctr_q[rd_idx];
  end
endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor #(
  parameter int NUM_SLOTS = lhp_pkg::DEF_SLOTS,
  parameter int HIST_W    = lhp_pkg::DEF_HIST_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_valid,
  input  logic [SLOT_W-1:0] pred_slot,
  input  logic              res_valid,
  input  logic [SLOT_W-1:0] res_slot,
  input  logic [HIST_W-1:0] res_tag,
  input  logic              res_pred,
  input  logic              res_taken,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic [HIST_W-1:0] rsp_tag
);
  logic              train_en;
  logic [HIST_W-1:0] train_idx;
  logic              train_bit;
  logic              fix_en;
  logic [SLOT_W-1:0] fix_slot;
  logic [HIST_W-1:0] fix_hist;
  logic [HIST_W-1:0] cur_hist;
  logic              cur_dir;

  lhp_resolve #(.NUM_SLOTS(NUM_SLOTS), .HIST_W(HIST_W)) u_resolve (
    .res_valid (res_valid),
    .res_slot  (res_slot),
    .res_tag   (res_tag),
    .res_pred  (res_pred),
    .res_taken (res_taken),
    .train_en  (train_en),
    .train_idx (train_idx),
    .train_bit (train_bit),
    .fix_en    (fix_en),
    .fix_slot  (fix_slot),
    .fix_hist  (fix_hist)
  );

  lhp_hist_bank #(.NUM_SLOTS(NUM_SLOTS), .HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .look_en   (pred_valid),
    .look_slot (pred_slot),
    .spec_bit  (cur_dir),
    .fix_en    (fix_en),
    .fix_slot  (fix_slot),
    .fix_hist  (fix_hist),
    .look_hist (cur_hist)
  );

  lhp_ctr_table #(.HIST_W(HIST_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (train_en),
    .wr_idx (train_idx),
    .wr_bit (train_bit),
    .rd_idx (cur_hist),
    .rd_bit (cur_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= pred_valid;
      if (pred_valid) begin
        rsp_taken <= cur_dir;
        rsp_tag   <= cur_hist;
      end
    end
  end
endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
  parameter int NUM_SLOTS = lhp_pkg::DEF_SLOTS,
  parameter int HIST_W    = lhp_pkg::DEF_HIST_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_valid,
  input logic [SLOT_W-1:0] pred_slot,
  input logic              res_valid,
  input logic [SLOT_W-1:0] res_slot,
  input logic [HIST_W-1:0] res_tag,
  input logic              res_pred,
  input logic              res_taken,
  input logic              rsp_valid,
  input logic              rsp_taken,
  input logic [HIST_W-1:0] rsp_tag
);
  logic              prev_clean;
  logic [SLOT_W-1:0] prev_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clean <= 1'b0;
      prev_slot  <= '0;
    end else begin
      prev_clean <= pred_valid && !res_valid;
      prev_slot  <= pred_slot;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !rsp_valid);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> rsp_valid);

  assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !rsp_valid);

  assert_spec_chain_R3: assert property (@(posedge clk) disable iff (rst)
    (prev_clean && pred_valid && !res_valid && pred_slot == prev_slot)
    |=> rsp_tag == {$past(rsp_tag[HIST_W-2:0]), $past(rsp_taken)});

  assert_repair_first_R8: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && res_valid && (res_pred != res_taken) && pred_slot == res_slot)
    |=> rsp_tag == {$past(res_tag[HIST_W-2:0]), $past(res_taken)});
endmodule

bind lhist_predictor lhp_checker #(.NUM_SLOTS(NUM_SLOTS), .HIST_W(HIST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pred_valid (pred_valid),
  .pred_slot  (pred_slot),
  .res_valid  (res_valid),
  .res_slot   (res_slot),
  .res_tag    (res_tag),
  .res_pred   (res_pred),
  .res_taken  (res_taken),
  .rsp_valid  (rsp_valid),
  .rsp_taken  (rsp_taken),
  .rsp_tag    (rsp_tag)
);

// File: tb/lhist_predictor_tb.sv
module lhist_predictor_tb;
  localparam int NS = 4;
  localparam int HW = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pred_valid = 1'b0;
  logic [SW-1:0] pred_slot = '0;
  logic          res_valid = 1'b0;
  logic [SW-1:0] res_slot = '0;
  logic [HW-1:0] res_tag = '0;
  logic          res_pred = 1'b0;
  logic          res_taken = 1'b0;
  logic          rsp_valid;
  logic          rsp_taken;
  logic [HW-1:0] rsp_tag;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lhist_predictor #(.NUM_SLOTS(NS), .HIST_W(HW)) u_dut (
    .clk(clk), .rst(rst),
    .pred_valid(pred_valid), .pred_slot(pred_slot),
    .res_valid(res_valid), .res_slot(res_slot), .res_tag(res_tag),
    .res_pred(res_pred), .res_taken(res_taken),
    .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_tag(rsp_tag)
  );

  typedef struct packed {
    logic          pv;
    logic [SW-1:0] ps;
    logic          rv;
    logic [SW-1:0] rs;
    logic [HW-1:0] rtag;
    logic          rpred;
    logic          rtaken;
    logic          ev;
    logic          et;
    logic [HW-1:0] etag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0},  // R1 R2 first lookup
    '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0},  // R3 shift of 0
    '{1'b0, 2'd0, 1'b1, 2'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 R10 repair slot0 -> 0001
    '{1'b1, 2'd1, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0},  // R5 ctr[0]=1
    '{1'b1, 2'd1, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1},  // R3
    '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1},  // R4 R7
    '{1'b1, 2'd1, 1'b1, 2'd1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R8 repair wins
    '{1'b1, 2'd0, 1'b1, 2'd0, 4'd2, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2},  // R6 R9 write-first
    '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R3 after taken
    '{1'b1, 2'd1, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R4 R8
    '{1'b0, 2'd0, 1'b1, 2'd0, 4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 drop younger
    '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11}, // R7 history 1011
    '{1'b1, 2'd2, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0},  // R4 R5 fresh slot2
    '{1'b1, 2'd2, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1}   // R5 ctr[1]=1
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic pv, input logic [SW-1:0] ps, input logic rv,
                       input logic [SW-1:0] rs, input logic [HW-1:0] rtag,
                       input logic rp, input logic rt);
    pred_valid = pv; pred_slot = ps;
    res_valid = rv; res_slot = rs; res_tag = rtag; res_pred = rp; res_taken = rt;
  endtask

  // apply inputs for one cycle, then land on the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].pv, TBL[i].ps, TBL[i].rv, TBL[i].rs, TBL[i].rtag,
            TBL[i].rpred, TBL[i].rtaken);
      step();
      chk($sformatf("row%0d R2/R10", i), "rsp_valid", int'(rsp_valid), int'(TBL[i].ev));
      if (TBL[i].ev) begin
        chk($sformatf("row%0d R2", i), "rsp_taken", int'(rsp_taken), int'(TBL[i].et));
        chk($sformatf("row%0d R3", i), "rsp_tag", int'(rsp_tag), int'(TBL[i].etag));
      end
    end

    // R1: mid-run reset clears trained counters (ctr[0] was 1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid during reset", int'(rsp_valid), 0);
    rst = 1'b0;
    drive(1'b1, 2'd2, 1'b0, '0, '0, 1'b0, 1'b0);
    step();
    chk("R1", "post-reset taken", int'(rsp_taken), 0);
    chk("R1", "post-reset tag", int'(rsp_tag), 0);

    // R6: correct resolve trains ctr[0]=1 but keeps slot3 history at 0
    drive(1'b0, '0, 1'b1, 2'd3, 4'd0, 1'b1, 1'b1);
    step();
    chk("R10", "no lookup no rsp", int'(rsp_valid), 0);
    drive(1'b1, 2'd3, 1'b0, '0, '0, 1'b0, 1'b0);
    step();
    chk("R6", "slot3 tag unchanged", int'(rsp_tag), 0);
    chk("R5", "slot3 trained taken", int'(rsp_taken), 1);

    // R4: slot3 lookup shifted 1; slot1 still at 0 also sees ctr[0]
    drive(1'b1, 2'd1, 1'b0, '0, '0, 1'b0, 1'b0);
    step();
    chk("R4", "slot1 tag independent", int'(rsp_tag), 0);
    drive(1'b1, 2'd3, 1'b0, '0, '0, 1'b0, 1'b0);
    step();
    chk("R3", "slot3 tag after taken", int'(rsp_tag), 1);
    chk("R3", "slot3 ctr[1] untrained", int'(rsp_taken), 0);

    finished = 1'b1;
    finish_run();
  end
endmodule